// File: doc/BRIEF.md
# Configurable Macrocell Storage Register

This block is one storage element of the kind found in each cell of a small programmable logic device, together with the clock generator that serves a group of such cells. Static configuration inputs choose the clock that drives the flop, the signal used as its clock enable, and how the group-wide and local initialization terms force it. The configuration is held on plain input ports, and nothing here writes it.

The clock generator turns the global clock inputs into a set of block clocks. Each block clock is one chosen global clock, either true or inverted. The flop then takes its clock from one of those block clocks, from the product-term clock (true or inverted), from the shared product-term clock, or from ground. A swap bit exchanges the reset and preset lines, and that choice also fixes the value loaded by the power-on reset.

Top module: `mcell_reg`

## Requirements
- R1: Block clock k is the global clock chosen by field `cfg_bclk_src_i[2k+1:2k]`, inverted when `cfg_bclk_inv_i[k]` is 1. With `cfg_clk_sel_i` = k (0 to 3) the register loads `d_i` on each rising edge of block clock k and ignores the other global clocks.
- R2: `cfg_clk_sel_i` = 4 clocks the register on rising `pt_clk_i`, 5 on falling `pt_clk_i`, and 6 on rising `shared_pt_clk_i`. Inputs not selected cause no load.
- R3: `cfg_clk_sel_i` = 7 ties the clock to ground. No clock input changes the stored value, but set and reset still act.
- R4: `cfg_ce_sel_i` picks the clock enable: 0 gives `pt_init_ce_i`, 1 gives its inverse, 2 gives `shared_pt_clk_i`, and 3 gives constant 1. On a clock edge with the enable at 0 the stored value is kept.
- R5: With `cfg_swap_i` = 0, the reset line is (`cfg_init_en_i` AND `blk_init_i`) OR `loc_rst_i` and the preset line is `loc_set_i`. Both act at once, without waiting for a clock.
- R6: With `cfg_swap_i` = 1, the two lines trade places. The block init term and `loc_rst_i` then drive q to 1, and `loc_set_i` drives q to 0.
- R7: After any swap, an active reset line holds q at 0, whatever the preset line and the clock do. An active preset line alone holds q at 1 against the clock.
- R8: While `rst_ni` is low, q equals the power-up value and clock edges are ignored. The power-up value is 1 when `cfg_init_en_i` and `cfg_swap_i` are both 1, and 0 otherwise.
- R9: With `cfg_init_en_i` = 0, `blk_init_i` has no effect on q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Power-on reset, active low; loads the power-up value |
| gclk_i | input | N_GCLK | Global clock inputs |
| pt_clk_i | input | 1 | Product-term clock |
| shared_pt_clk_i | input | 1 | Shared product-term clock; also a clock enable source |
| pt_init_ce_i | input | 1 | Product-term init / clock enable term |
| blk_init_i | input | 1 | Block-level initialization, common to the group |
| loc_set_i | input | 1 | Local preset product term |
| loc_rst_i | input | 1 | Local reset product term |
| d_i | input | 1 | Data input |
| cfg_bclk_src_i | input | N_BCLK*GSEL_W | Global clock index for each block clock |
| cfg_bclk_inv_i | input | N_BCLK | Inversion for each block clock |
| cfg_clk_sel_i | input | CSEL_W | Clock source select |
| cfg_ce_sel_i | input | 2 | Clock enable source select |
| cfg_init_en_i | input | 1 | Lets the block init term reach the register |
| cfg_swap_i | input | 1 | Exchanges the reset and preset lines |
| q_o | output | 1 | Register value |

## Verification
For each clock select setting, every raw clock input is pulsed in turn while the data input holds the inverse of the stored value. A load therefore shows as a flip, and a pulse on an unselected input shows as no change, which separates the true and inverted edges and the block clock mapping. Clock enable settings are tried with all four level pairs of the init/enable term and the shared clock. The set and reset terms are asserted singly and in overlapping orders, with the clock grounded and with it active, under all four init-enable and swap combinations. Each power-up value is checked with clock pulses applied while reset is held.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;
  typedef enum logic [1:0] {
    CE_PT     = 2'd0,
    CE_PT_N   = 2'd1,
    CE_SHARED = 2'd2,
    CE_ONE    = 2'd3
  } ce_sel_e;

  // product-term clock, its inverse, shared clock, ground
  localparam int unsigned N_FIXED_CLK = 4;
endpackage

// File: rtl/mcell_clk_gen.sv
`timescale 1ns/1ps
module mcell_clk_gen #(
  parameter int N_GCLK = 4,
  parameter int N_BCLK = 4,
  parameter int GSEL_W = 2
) (
  input  logic [N_GCLK-1:0]        gclk_i,
  input  logic [N_BCLK*GSEL_W-1:0] src_i,
  input  logic [N_BCLK-1:0]        inv_i,
  output logic [N_BCLK-1:0]        bclk_o
);
  for (genvar b = 0; b < N_BCLK; b++) begin : g_bclk
    logic raw;
    always_comb begin
      raw = 1'b0;
      for (int j = 0; j < N_GCLK; j++) begin
        if (int'(src_i[b*GSEL_W +: GSEL_W]) == j) raw = gclk_i[j];
      end
    end
    assign bclk_o[b] = raw ^ inv_i[b];
  end
endmodule

// File: rtl/mcell_clk_mux.sv
`timescale 1ns/1ps
module mcell_clk_mux #(
  parameter int N_BCLK = 4,
  parameter int CSEL_W = 3
) (
  input  logic [N_BCLK-1:0] bclk_i,
  input  logic              pt_clk_i,
  input  logic              shared_clk_i,
  input  logic [CSEL_W-1:0] sel_i,
  output logic              clk_o
);
  always_comb begin
    clk_o = 1'b0;  // ground unless a source matches
    for (int k = 0; k < N_BCLK; k++) begin
      if (int'(sel_i) == k) clk_o = bclk_i[k];
    end
    if (int'(sel_i) == N_BCLK)     clk_o = pt_clk_i;
    if (int'(sel_i) == N_BCLK + 1) clk_o = ~pt_clk_i;
    if (int'(sel_i) == N_BCLK + 2) clk_o = shared_clk_i;
  end
endmodule

// File: rtl/mcell_init_ctl.sv
`timescale 1ns/1ps
module mcell_init_ctl (
  input  logic init_en_i,
  input  logic swap_i,
  input  logic blk_init_i,
  input  logic loc_set_i,
  input  logic loc_rst_i,
  output logic arst_o,
  output logic aset_o,
  output logic pu_o
);
  logic clr_line;
  logic pre_line;

  assign clr_line = (init_en_i & blk_init_i) | loc_rst_i;
  assign pre_line = loc_set_i;

  assign arst_o = swap_i ? pre_line : clr_line;
  assign aset_o = swap_i ? clr_line : pre_line;
  // swapped block init sets the cell, so it also powers up set
  assign pu_o   = init_en_i & swap_i;
endmodule

// File: rtl/mcell_ff.sv
`timescale 1ns/1ps
module mcell_ff
  import mcell_pkg::*;
(
  input  logic    rst_ni,
  input  logic    clk_i,
  input  logic    arst_i,
  input  logic    aset_i,
  input  logic    pu_i,
  input  ce_sel_e ce_sel_i,
  input  logic    pt_ce_i,
  input  logic    shared_i,
  input  logic    d_i,
  output logic    ce_o,
  output logic    q_o
);
  always_comb begin
    case (ce_sel_i)
      CE_PT:     ce_o = pt_ce_i;
      CE_PT_N:   ce_o = ~pt_ce_i;
      CE_SHARED: ce_o = shared_i;
      default:   ce_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or posedge arst_i or posedge aset_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= pu_i;
    else if (arst_i) q_o <= 1'b0;
    else if (aset_i) q_o <= 1'b1;
    else if (ce_o)   q_o <= d_i;
  end
endmodule

// File: rtl/mcell_reg.sv
`timescale 1ns/1ps
module mcell_reg
  import mcell_pkg::*;
#(
  parameter  int N_GCLK = 4,
  parameter  int N_BCLK = 4,
  localparam int GSEL_W = (N_GCLK > 1) ? $clog2(N_GCLK) : 1,
  localparam int CSEL_W = $clog2(N_BCLK + N_FIXED_CLK)
) (
  input  logic                     rst_ni,
  input  logic [N_GCLK-1:0]        gclk_i,
  input  logic                     pt_clk_i,
  input  logic                     shared_pt_clk_i,
  input  logic                     pt_init_ce_i,
  input  logic                     blk_init_i,
  input  logic                     loc_set_i,
  input  logic                     loc_rst_i,
  input  logic                     d_i,
  input  logic [N_BCLK*GSEL_W-1:0] cfg_bclk_src_i,
  input  logic [N_BCLK-1:0]        cfg_bclk_inv_i,
  input  logic [CSEL_W-1:0]        cfg_clk_sel_i,
  input  logic [1:0]               cfg_ce_sel_i,
  input  logic                     cfg_init_en_i,
  input  logic                     cfg_swap_i,
  output logic                     q_o
);
  logic [N_BCLK-1:0] bclk;
  logic              clk_eff;
  logic              arst;
  logic              aset;
  logic              pu_val;
  logic              ce_eff;

  mcell_clk_gen #(
    .N_GCLK(N_GCLK),
    .N_BCLK(N_BCLK),
    .GSEL_W(GSEL_W)
  ) clk_gen_i (
    .gclk_i (gclk_i),
    .src_i  (cfg_bclk_src_i),
    .inv_i  (cfg_bclk_inv_i),
    .bclk_o (bclk)
  );

  mcell_clk_mux #(
    .N_BCLK(N_BCLK),
    .CSEL_W(CSEL_W)
  ) clk_mux_i (
    .bclk_i       (bclk),
    .pt_clk_i     (pt_clk_i),
    .shared_clk_i (shared_pt_clk_i),
    .sel_i        (cfg_clk_sel_i),
    .clk_o        (clk_eff)
  );

  mcell_init_ctl init_ctl_i (
    .init_en_i  (cfg_init_en_i),
    .swap_i     (cfg_swap_i),
    .blk_init_i (blk_init_i),
    .loc_set_i  (loc_set_i),
    .loc_rst_i  (loc_rst_i),
    .arst_o     (arst),
    .aset_o     (aset),
    .pu_o       (pu_val)
  );

  mcell_ff ff_i (
    .rst_ni   (rst_ni),
    .clk_i    (clk_eff),
    .arst_i   (arst),
    .aset_i   (aset),
    .pu_i     (pu_val),
    .ce_sel_i (ce_sel_e'(cfg_ce_sel_i)),
    .pt_ce_i  (pt_init_ce_i),
    .shared_i (shared_pt_clk_i),
    .d_i      (d_i),
    .ce_o     (ce_eff),
    .q_o      (q_o)
  );
endmodule

// File: rtl/mcell_reg_chk.sv
`timescale 1ns/1ps
module mcell_reg_chk #(
  parameter int CSEL_W   = 3,
  parameter int GND_CODE = 7
) (
  input logic              rst_ni,
  input logic              clk_i,
  input logic              arst_i,
  input logic              aset_i,
  input logic              ce_i,
  input logic              q_i,
  input logic [CSEL_W-1:0] clk_sel_i,
  input logic [1:0]        ce_sel_i
);
  localparam logic [CSEL_W-1:0] GND_SEL = CSEL_W'(GND_CODE);

  AST_RST_DOMINATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arst_i |-> (q_i == 1'b0)); // R7

  AST_SET_FORCES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aset_i && !arst_i) |-> (q_i == 1'b1)); // R5

  AST_GND_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_i != GND_SEL); // R3

  AST_CE_TIED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_sel_i == 2'd3) |-> ce_i); // R4
endmodule

bind mcell_reg mcell_reg_chk #(
  .CSEL_W   (CSEL_W),
  .GND_CODE (N_BCLK + 3)
) chk_i (
  .rst_ni    (rst_ni),
  .clk_i     (clk_eff),
  .arst_i    (arst),
  .aset_i    (aset),
  .ce_i      (ce_eff),
  .q_i       (q_o),
  .clk_sel_i (cfg_clk_sel_i),
  .ce_sel_i  (cfg_ce_sel_i)
);

// File: tb/mcell_reg_tb_top.sv
`timescale 1ns/1ps
module mcell_reg_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni = 1'b1;
  logic [3:0] gclk = '0;
  logic       pt_clk = 1'b0, sh_clk = 1'b0, pt_ce = 1'b0;
  logic       blk_init = 1'b0, loc_set = 1'b0, loc_rst = 1'b0, d = 1'b0;
  logic [7:0] cfg_src = {2'd1, 2'd3, 2'd0, 2'd2};
  logic [3:0] cfg_inv = 4'b1010;
  logic [2:0] cfg_csel = 3'd0;
  logic [1:0] cfg_cesel = 2'd3;
  logic       cfg_en = 1'b0, cfg_swap = 1'b0;
  logic       q;

  // next-step values
  logic [3:0] nx_g = '0;
  logic       nx_pc = 1'b0, nx_sh = 1'b0, nx_pce = 1'b0;
  logic       nx_bi = 1'b0, nx_ls = 1'b0, nx_lr = 1'b0, nx_d = 1'b0;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  // reference model state
  int   mdl_src[4] = '{2, 0, 3, 1};
  int   mdl_inv[4] = '{0, 1, 0, 1};
  logic q_m = 1'b0;
  logic prev_lvl = 1'b0;

  mcell_reg dut_i (
    .rst_ni          (rst_ni),
    .gclk_i          (gclk),
    .pt_clk_i        (pt_clk),
    .shared_pt_clk_i (sh_clk),
    .pt_init_ce_i    (pt_ce),
    .blk_init_i      (blk_init),
    .loc_set_i       (loc_set),
    .loc_rst_i       (loc_rst),
    .d_i             (d),
    .cfg_bclk_src_i  (cfg_src),
    .cfg_bclk_inv_i  (cfg_inv),
    .cfg_clk_sel_i   (cfg_csel),
    .cfg_ce_sel_i    (cfg_cesel),
    .cfg_init_en_i   (cfg_en),
    .cfg_swap_i      (cfg_swap),
    .q_o             (q)
  );

  function automatic logic sel_lvl();
    int cs = int'(cfg_csel);
    if (cs < 4) return gclk[mdl_src[cs]] ^ (mdl_inv[cs] != 0);
    if (cs == 4) return pt_clk;
    if (cs == 5) return ~pt_clk;
    if (cs == 6) return sh_clk;
    return 1'b0;
  endfunction

  function automatic logic ce_m();
    case (cfg_cesel)
      2'd0:    return pt_ce;
      2'd1:    return ~pt_ce;
      2'd2:    return sh_clk;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic pu_m();
    return cfg_en & cfg_swap;
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (q !== q_m) begin
      miscompares++;
      $display("FAIL %s: q=%0b expected %0b (csel=%0d cesel=%0d en=%0b swap=%0b)",
               tag, q, q_m, cfg_csel, cfg_cesel, cfg_en, cfg_swap);
    end
  endtask

  task automatic model_step();
    logic lvl, rise, clr_l, pre_l, rl, pl;
    lvl = sel_lvl();
    rise = lvl & ~prev_lvl;
    prev_lvl = lvl;
    clr_l = (cfg_en & blk_init) | loc_rst;
    pre_l = loc_set;
    rl = cfg_swap ? pre_l : clr_l;
    pl = cfg_swap ? clr_l : pre_l;
    if (!rst_ni)              q_m = pu_m();
    else if (rl)              q_m = 1'b0;
    else if (pl)              q_m = 1'b1;
    else if (rise && ce_m())  q_m = d;
  endtask

  // data and init terms first, shared clock next, other clocks last
  task automatic apply(input string tag);
    @(negedge clk);
    d = nx_d; pt_ce = nx_pce; blk_init = nx_bi; loc_set = nx_ls; loc_rst = nx_lr;
    #1 sh_clk = nx_sh;
    #1 gclk = nx_g; pt_clk = nx_pc;
    model_step();
    @(posedge clk);
    check(tag);
  endtask

  task automatic toggle(input int s);
    if (s < 4)       nx_g[s] = ~nx_g[s];
    else if (s == 4) nx_pc = ~nx_pc;
    else             nx_sh = ~nx_sh;
  endtask

  task automatic pulse(input int s, input string tag);
    nx_d = ~q_m;
    toggle(s);
    apply(tag);
    toggle(s);
    apply(tag);
  endtask

  // config changes only under reset; a second reset edge loads the new power-up value
  task automatic set_cfg(input int cs, input int ce, input logic en, input logic sw);
    @(negedge clk);
    rst_ni = 1'b0;
    #1 cfg_csel = 3'(cs); cfg_cesel = 2'(ce); cfg_en = en; cfg_swap = sw;
    #1 rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    q_m = pu_m();
    prev_lvl = sel_lvl();
    @(posedge clk);
    check("R8");
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    check("R8");
  endtask

  task automatic async_seq(input int cs);
    string t_bi, t_loc;
    for (int m = 0; m < 4; m++) begin
      logic en, sw;
      en = m[1]; sw = m[0];
      t_loc = sw ? "R6" : "R5";
      t_bi  = en ? t_loc : "R9";
      set_cfg(cs, 3, en, sw);
      release_rst();
      nx_bi = 1'b1; apply(t_bi);
      nx_bi = 1'b0; apply(t_bi);
      nx_ls = 1'b1; apply(t_loc);
      nx_ls = 1'b0; apply(t_loc);
      nx_lr = 1'b1; apply(t_loc);
      nx_lr = 1'b0; apply(t_loc);
      // overlap: preset line first, then reset line, released together
      nx_ls = 1'b1; apply("R7");
      nx_lr = 1'b1; apply("R7");
      nx_ls = 1'b0; nx_lr = 1'b0; apply("R7");
      nx_lr = 1'b1; apply("R7");
      nx_ls = 1'b1; apply("R7");
      nx_ls = 1'b0; nx_lr = 1'b0; apply("R7");
      nx_bi = 1'b1; apply("R7");
      nx_ls = 1'b1; apply("R7");
      nx_bi = 1'b0; nx_ls = 1'b0; apply("R7");
      nx_ls = 1'b1; apply("R7");
      nx_bi = 1'b1; apply("R7");
      nx_bi = 1'b0; nx_ls = 1'b0; apply("R7");
      // held init term against clock pulses
      nx_lr = 1'b1; apply("R7");
      pulse(4, "R7");
      nx_lr = 1'b0; apply("R7");
      nx_ls = 1'b1; apply("R7");
      pulse(4, "R7");
      nx_ls = 1'b0; apply("R7");
      pulse(4, (cs == 7) ? "R3" : "R2");
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, act=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R8: power-up value per init configuration, clocks ignored in reset
    for (int m = 0; m < 4; m++) begin
      set_cfg(4, 3, m[1], m[0]);
      pulse(4, "R8");
      pulse(0, "R8");
      release_rst();
      pulse(4, "R8");
    end

    // R1, R2, R3: every clock select against every raw clock input
    for (int cs = 0; cs < 8; cs++) begin
      string t;
      t = (cs < 4) ? "R1" : ((cs == 7) ? "R3" : "R2");
      set_cfg(cs, 3, 1'b0, 1'b0);
      release_rst();
      for (int s = 0; s < 6; s++) begin
        pulse(s, t);
        pulse(s, t);
      end
    end

    // R4: every enable select with all enable level pairs
    for (int ce = 0; ce < 4; ce++) begin
      set_cfg(4, ce, 1'b0, 1'b0);
      release_rst();
      for (int v = 0; v < 4; v++) begin
        nx_pce = v[0];
        nx_sh  = v[1];
        apply("R4");
        pulse(4, "R4");
        pulse(5, "R4");
      end
      nx_pce = 1'b0;
      nx_sh  = 1'b0;
      apply("R4");
    end

    // R5, R6, R7, R9: init terms with clock grounded and with clock active
    async_seq(7);
    async_seq(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule